// File: doc/BRIEF.md
# SPI CAN-controller command sequencer

This block is an SPI master that runs complete command transactions against an external CAN controller chip on behalf of a host. The host starts one request at a time. The block then drives chip select, the serial clock and the data line through the whole opcode-framed byte sequence, and reports completion.

There are five request kinds:
- register read
- register write
- single-bit modify
- receive-buffer fast read
- transmit-buffer load, which the block follows with its own transmit-request write

The block converts between a plain 29-bit identifier and the chip's packed four-byte identifier layout in both directions. It returns received identifiers, the extended flag, the length and the data bytes as parallel fields.

A request is presented on the host fields together with a one-cycle `start` pulse while the block is idle. The serial clock runs in SPI mode 0 at one bit per `2*CLK_DIV` system clocks. Chip select is released between every pair of transactions. This includes the two transactions that make up a transmit load.

Top module: `can_spi_sequencer`

## Requirements
- R1: Read (op code 0) sends 0x03, `addr` and one dummy byte 0x00 in one chip-select-low window. The byte received during the dummy byte appears on `rdata` when `done` pulses.
- R2: Write (op code 1) sends 0x02, `addr`, `wdata` in one window.
- R3: Bit modify (op code 2) sends 0x05, `addr`, the mask `1 << bit_idx`, and then 0xFF when `bit_set` is 1 or 0x00 when it is 0.
- R4: Receive fast read (op code 3) sends opcode 0x90 when `buf_sel[0]` is 0 and 0x94 when it is 1. It then clocks dummy 0x00 bytes to collect four identifier bytes (most significant first) and a length byte. Only the length byte's low nibble is kept, clamped to 8. Exactly that many data bytes follow. Data byte k lands in `rx_data[8k+7:8k]`, unreceived bytes read 0, and `rx_len` holds the clamped length.
- R5: With W the 32-bit word from the four identifier bytes, `rx_ext` = W[19]. If set, `rx_id` = {W[31:21], W[17:0]}. Otherwise `rx_id` = W[31:21] zero-extended.
- R6: Transmit load (op code 4) sends 0x40/0x42/0x44 for `buf_sel` 0/1/2, with `buf_sel` 3 treated as 2. Next come four identifier bytes, most significant first. For an extended frame these are the word ((id & 0x1FFC0000) << 3) | (id & 0x3FFFF) | 0x80000. For a standard frame they are id[10:3], id[2:0] in bits 7:5, 0x00, 0x00. Then come the length byte (clamped length in the low nibble) and that many data bytes from `tx_data`, byte k from bits [8k+7:8k].
- R7: After the load window closes, a second window writes 0x02, control address 0x30/0x40/0x50 for buffer 0/1/2, and the value 0x08 | `tx_prio`.
- R8: SPI mode 0: `spi_sck` is low whenever chip select is high. `spi_mosi` does not change on the cycle `spi_sck` rises. Bits are sent most significant first.
- R9: `spi_cs_n` stays high for at least `2*CLK_DIV` system clocks between any two windows.
- R10: `start` is accepted only when idle with an op code of 0 to 4. `busy` is high from the next cycle until the request ends. `done` is a one-cycle pulse in the first idle cycle. A `start` while busy, or with op code 5 to 7, has no effect.
- R11: A transmit `tx_len` above 8 is clamped to 8 for both the length byte and the number of data bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| op | input | 3 | Request kind, 0 to 4 |
| addr | input | 8 | Register address for read, write, modify |
| wdata | input | 8 | Write value |
| bit_idx | input | 3 | Bit position for modify |
| bit_set | input | 1 | Modify sets (1) or clears (0) the bit |
| buf_sel | input | 2 | Buffer number for fast read and transmit load |
| tx_id | input | 29 | Transmit identifier |
| tx_ext | input | 1 | Transmit frame uses the extended identifier |
| tx_len | input | 4 | Transmit data length |
| tx_data | input | 64 | Transmit data bytes |
| tx_prio | input | 2 | Transmit priority, 3 highest |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished pulse |
| rdata | output | 8 | Register read result |
| rx_id | output | 29 | Received identifier |
| rx_ext | output | 1 | Received frame is extended |
| rx_len | output | 4 | Received data length |
| rx_data | output | 64 | Received data bytes |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the chip |
| spi_miso | input | 1 | SPI data from the chip |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
Several properties are checked on every cycle: the serial-clock idle level and data stability at rising edges, the minimum chip-select high time, the single-cycle completion pulse, and the rule that no chip-select window opens while idle or after a bad op code. Only the bench scenarios can show the rest. That covers the byte content and order of each opcode sequence, the two-window transmit load, identifier packing and unpacking in both modes, and length clamping on both paths. A modelled chip captures every window and compares it against the expected byte queue.

// File: rtl/can_seq_pkg.sv
package can_seq_pkg;

   typedef enum logic [2:0] {
      OP_RDREG  = 3'd0,
      OP_WRREG  = 3'd1,
      OP_BITMOD = 3'd2,
      OP_RXFAST = 3'd3,
      OP_TXLOAD = 3'd4
   } seq_op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_SETUP, S_NEXT, S_XFER, S_HOLD, S_GAP
   } seq_st_e;

   localparam logic [7:0] CMD_READ   = 8'h03;
   localparam logic [7:0] CMD_WRITE  = 8'h02;
   localparam logic [7:0] CMD_MODIFY = 8'h05;

   function automatic logic [3:0] clamp_len(input logic [3:0] l, input logic [3:0] cap);
      return (l > cap) ? cap : l;
   endfunction

endpackage

// File: rtl/can_spi_shifter.sv
module can_spi_shifter #(
   parameter int CLK_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       fin,
   output logic [7:0] rx_byte
);
   localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end

   logic          run;
   logic [CW-1:0] div_cnt;
   logic [3:0]    edge_cnt;
   logic [7:0]    sr_tx, sr_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0; div_cnt <= '0; edge_cnt <= '0; sck <= 1'b0;
         sr_tx <= '0; sr_rx <= '0; fin <= 1'b0; rx_byte <= '0;
      end else begin
         fin <= 1'b0;
         if (launch) begin
            run <= 1'b1; sr_tx <= tx_byte; div_cnt <= '0; edge_cnt <= '0; sck <= 1'b0;
         end else if (run) begin
            if (div_cnt == CW'(CLK_DIV - 1)) begin
               div_cnt  <= '0;
               sck      <= ~sck;
               edge_cnt <= edge_cnt + 4'd1;
               if (!sck) begin
                  sr_rx <= {sr_rx[6:0], miso};
               end else begin
                  sr_tx <= {sr_tx[6:0], 1'b0};
                  if (edge_cnt == 4'd15) begin
                     run <= 1'b0; fin <= 1'b1; rx_byte <= sr_rx;
                  end
               end
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end
      end
   end

   assign mosi = sr_tx[7];
endmodule

// File: rtl/can_id_codec.sv
module can_id_codec #(
   parameter int ID_W = 29
) (
   input  logic [ID_W-1:0] tx_id,
   input  logic            tx_ext,
   output logic [31:0]     tx_word,
   input  logic [31:0]     rx_word,
   output logic [ID_W-1:0] rx_id,
   output logic            rx_ext
);
   if (ID_W != 29) begin : g_bad_w
      $error("identifier layout fixes ID_W at 29");
   end

   logic unused_gap;
   assign unused_gap = ^{rx_word[20], rx_word[18]};

   assign tx_word = tx_ext ? {tx_id[28:18], 3'b010, tx_id[17:0]}
                           : {tx_id[10:0], 21'd0};
   assign rx_ext  = rx_word[19];
   assign rx_id   = rx_ext ? {rx_word[31:21], rx_word[17:0]}
                           : {18'd0, rx_word[31:21]};
endmodule

// File: rtl/can_spi_sequencer.sv
module can_spi_sequencer
   import can_seq_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int LEN_CAP = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [2:0]  op,
   input  logic [7:0]  addr,
   input  logic [7:0]  wdata,
   input  logic [2:0]  bit_idx,
   input  logic        bit_set,
   input  logic [1:0]  buf_sel,
   input  logic [28:0] tx_id,
   input  logic        tx_ext,
   input  logic [3:0]  tx_len,
   input  logic [63:0] tx_data,
   input  logic [1:0]  tx_prio,
   output logic        busy,
   output logic        done,
   output logic [7:0]  rdata,
   output logic [28:0] rx_id,
   output logic        rx_ext,
   output logic [3:0]  rx_len,
   output logic [63:0] rx_data,
   output logic        spi_sck,
   output logic        spi_mosi,
   input  logic        spi_miso,
   output logic        spi_cs_n
);
   localparam int          TW  = $clog2(2 * CLK_DIV + 1);
   localparam logic [3:0]  CAP = 4'(LEN_CAP);

   if (LEN_CAP < 1 || LEN_CAP > 8) begin : g_bad_cap
      $error("LEN_CAP must lie in 1..8");
   end

   seq_st_e     state;
   seq_op_e     op_q;
   logic [TW-1:0] tim;
   logic [4:0]  idx, n_b;
   logic        phase_q, set_q;
   logic [7:0]  addr_q, wdata_q, out_b, rx_b;
   logic [2:0]  bit_q, dsel;
   logic [1:0]  buf_q, prio_q;
   logic [28:0] id_q;
   logic        ext_q;
   logic [3:0]  tlen_q;
   logic [63:0] txd_q;
   logic [31:0] txw, raw_q;
   logic        sh_launch, sh_fin;

   assign dsel = 3'(idx - 5'd6);

   can_id_codec #(.ID_W(29)) u_codec (
      .tx_id(id_q), .tx_ext(ext_q), .tx_word(txw),
      .rx_word(raw_q), .rx_id(rx_id), .rx_ext(rx_ext)
   );

   can_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .launch(sh_launch), .tx_byte(out_b),
      .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .fin(sh_fin), .rx_byte(rx_b)
   );

   // byte to send at position idx and length of the current window
   always_comb begin
      out_b = 8'h00;
      n_b   = 5'd3;
      case (op_q)
         OP_RDREG: if (idx == 5'd0) out_b = CMD_READ; else if (idx == 5'd1) out_b = addr_q;
         OP_WRREG: case (idx)
               5'd0:    out_b = CMD_WRITE;
               5'd1:    out_b = addr_q;
               default: out_b = wdata_q;
            endcase
         OP_BITMOD: begin
            n_b = 5'd4;
            case (idx)
               5'd0:    out_b = CMD_MODIFY;
               5'd1:    out_b = addr_q;
               5'd2:    out_b = 8'd1 << bit_q;
               default: out_b = {8{set_q}};
            endcase
         end
         OP_RXFAST: begin
            n_b = 5'd6 + {1'b0, rx_len};
            if (idx == 5'd0) out_b = {5'b10010, buf_q[0], 2'b00};
         end
         default: begin
            if (!phase_q) begin
               n_b = 5'd6 + {1'b0, tlen_q};
               case (idx)
                  5'd0:    out_b = {5'b01000, buf_q, 1'b0};
                  5'd1:    out_b = txw[31:24];
                  5'd2:    out_b = txw[23:16];
                  5'd3:    out_b = txw[15:8];
                  5'd4:    out_b = txw[7:0];
                  5'd5:    out_b = {4'd0, tlen_q};
                  default: out_b = txd_q[{dsel, 3'b000} +: 8];
               endcase
            end else begin
               case (idx)
                  5'd0:    out_b = CMD_WRITE;
                  5'd1:    out_b = {4'd3 + {2'b00, buf_q}, 4'd0};
                  default: out_b = {4'd0, 1'b1, 1'b0, prio_q};
               endcase
            end
         end
      endcase
   end

   assign sh_launch = (state == S_NEXT) && (idx != n_b);
   assign spi_cs_n  = (state == S_IDLE) || (state == S_GAP);
   assign busy      = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE; op_q <= OP_RDREG; tim <= '0; idx <= '0; phase_q <= 1'b0;
         set_q <= 1'b0; addr_q <= '0; wdata_q <= '0; bit_q <= '0; buf_q <= '0;
         prio_q <= '0; id_q <= '0; ext_q <= 1'b0; tlen_q <= '0; txd_q <= '0;
         raw_q <= '0; rx_len <= '0; rx_data <= '0; rdata <= '0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: if (start && op <= 3'd4) begin
               op_q <= seq_op_e'(op);
               addr_q <= addr; wdata_q <= wdata; bit_q <= bit_idx; set_q <= bit_set;
               buf_q <= (buf_sel == 2'd3) ? 2'd2 : buf_sel;
               prio_q <= tx_prio; id_q <= tx_id; ext_q <= tx_ext;
               tlen_q <= clamp_len(tx_len, CAP); txd_q <= tx_data;
               raw_q <= '0; rx_len <= '0; rx_data <= '0;
               idx <= '0; phase_q <= 1'b0; tim <= '0; state <= S_SETUP;
            end
            S_SETUP: if (tim == TW'(CLK_DIV - 1)) begin
               tim <= '0; state <= S_NEXT;
            end else tim <= tim + 1'b1;
            S_NEXT: state <= (idx == n_b) ? S_HOLD : S_XFER;
            S_XFER: if (sh_fin) begin
               if (op_q == OP_RDREG && idx == 5'd2) rdata <= rx_b;
               if (op_q == OP_RXFAST) begin
                  if (idx >= 5'd1 && idx <= 5'd4) raw_q <= {raw_q[23:0], rx_b};
                  else if (idx == 5'd5)           rx_len <= clamp_len(rx_b[3:0], CAP);
                  else if (idx >= 5'd6)           rx_data[{dsel, 3'b000} +: 8] <= rx_b;
               end
               idx <= idx + 5'd1;
               state <= S_NEXT;
            end
            S_HOLD: if (tim == TW'(CLK_DIV - 1)) begin
               tim <= '0; state <= S_GAP;
            end else tim <= tim + 1'b1;
            default: if (tim == TW'(2 * CLK_DIV - 1)) begin
               tim <= '0;
               if (op_q == OP_TXLOAD && !phase_q) begin
                  phase_q <= 1'b1; idx <= '0; state <= S_SETUP;
               end else begin
                  state <= S_IDLE; done <= 1'b1;
               end
            end else tim <= tim + 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/can_seq_checker.sv
module can_seq_checker #(
   parameter int CLK_DIV = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       sck,
   input logic       mosi,
   input logic       busy,
   input logic       done,
   input logic       start,
   input logic [2:0] op
);
   localparam int GW = $clog2(2 * CLK_DIV + 1);
   localparam logic [GW-1:0] GMAX = GW'(2 * CLK_DIV);

   logic [GW-1:0] gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    gap <= GMAX;
      else if (cs_n) gap <= (gap == GMAX) ? gap : gap + 1'b1;
      else           gap <= '0;
   end

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R8
   AST_MOSI_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> $stable(mosi)); // R8
   AST_CS_MIN_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> gap == GMAX); // R9
   AST_DONE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
   AST_DONE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R10
   AST_IDLE_NO_CS:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n); // R10
   AST_BAD_OP_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) (!busy && start && op > 3'd4) |=> !busy); // R10
endmodule

bind can_spi_sequencer can_seq_checker #(.CLK_DIV(CLK_DIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
   .busy(busy), .done(done), .start(start), .op(op)
);

// File: tb/test_can_spi_sequencer.sv
module test_can_spi_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 2;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [2:0] op = '0; logic [7:0] addr = '0, wdata = '0; logic [2:0] bit_idx = '0;
   logic bit_set = 1'b0; logic [1:0] buf_sel = '0; logic [28:0] tx_id = '0;
   logic tx_ext = 1'b0; logic [3:0] tx_len = '0; logic [63:0] tx_data = '0; logic [1:0] tx_prio = '0;
   logic busy, done, rx_ext, spi_sck, spi_mosi, spi_miso, spi_cs_n;
   logic [7:0] rdata; logic [28:0] rx_id; logic [3:0] rx_len; logic [63:0] rx_data;

   int errors = 0, checks = 0, frames = 0;
   logic [7:0] resp [32];
   logic [7:0] exp_b [$];
   int exp_n [$];
   string exp_tag [$];
   logic [7:0] osr = 8'h00;

   always #(CLK_PERIOD / 2) clk = ~clk;
   assign spi_miso = osr[7];

   can_spi_sequencer #(.CLK_DIV(DIV), .LEN_CAP(8)) i_can_spi_sequencer (.*);

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pb(input logic [7:0] b); exp_b.push_back(b); endtask
   task automatic close_frame(input string tag, input int n); exp_n.push_back(n); exp_tag.push_back(tag); endtask

   // chip model and monitor: captures each window and pops the expected bytes
   initial begin
      logic [7:0] cap [32];
      logic [7:0] isr;
      int nb, bc, n;
      string tg;
      forever begin
         @(negedge spi_cs_n);
         nb = 0; bc = 0; osr = resp[0]; isr = 8'h00;
         forever begin
            @(posedge spi_sck or posedge spi_cs_n);
            if (spi_cs_n) break;
            isr = {isr[6:0], spi_mosi}; bc++;
            @(negedge spi_sck);
            if (bc == 8) begin
               if (nb < 32) cap[nb] = isr;
               nb++; bc = 0;
               osr = (nb < 32) ? resp[nb] : 8'h00;
            end else osr = {osr[6:0], 1'b0};
         end
         frames++;
         if (exp_n.size() == 0) chk(1'b0, "R10 unexpected window", 64'(nb), 0);
         else begin
            n = exp_n.pop_front(); tg = exp_tag.pop_front();
            chk(nb == n, {tg, " byte count"}, 64'(nb), 64'(n));
            for (int i = 0; i < n; i++) begin
               logic [7:0] e;
               e = exp_b.pop_front();
               if (i < nb && i < 32) chk(cap[i] == e, $sformatf("%s byte %0d", tg, i), cap[i], e);
            end
         end
      end
   end

   task automatic run_req(input logic [2:0] o);
      @(negedge clk); op = o; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
      chk(!busy, "R10 busy low with done", busy, 0);
   endtask

   task automatic clear_resp(); for (int i = 0; i < 32; i++) resp[i] = 8'h00; endtask

   function automatic logic [31:0] pack_ext(input logic [28:0] id);
      logic [31:0] w;
      w = {3'b000, id};
      return ((w & 32'h1FFC0000) << 3) | (w & 32'h0003FFFF) | 32'h00080000;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] w;
      logic [63:0] ed;
      int f0;
      clear_resp();
      repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
      chk(spi_cs_n && !spi_sck && !busy && !done, "R10 reset state",
          {spi_cs_n, spi_sck, busy, done}, 4'b1000);

      // R1 register read
      addr = 8'h2C; resp[2] = 8'hA5;
      pb(8'h03); pb(8'h2C); pb(8'h00); close_frame("R1", 3);
      run_req(3'd0);
      chk(rdata == 8'hA5, "R1 rdata", rdata, 8'hA5);

      // R2 register write
      addr = 8'h0F; wdata = 8'h80;
      pb(8'h02); pb(8'h0F); pb(8'h80); close_frame("R2", 3);
      run_req(3'd1);

      // R3 modify, set and clear
      addr = 8'h2B; bit_idx = 3'd5; bit_set = 1'b1;
      pb(8'h05); pb(8'h2B); pb(8'h20); pb(8'hFF); close_frame("R3 set", 4);
      run_req(3'd2);
      bit_idx = 3'd0; bit_set = 1'b0;
      pb(8'h05); pb(8'h2B); pb(8'h01); pb(8'h00); close_frame("R3 clear", 4);
      run_req(3'd2);

      // R4/R5 fast read buffer 0, standard id with junk in low bits, upper length nibble ignored
      clear_resp();
      w = (32'h123 << 21) | 32'h00012345;
      resp[1] = w[31:24]; resp[2] = w[23:16]; resp[3] = w[15:8]; resp[4] = w[7:0];
      resp[5] = 8'hF3; resp[6] = 8'h11; resp[7] = 8'h22; resp[8] = 8'h33;
      buf_sel = 2'd0;
      pb(8'h90); for (int i = 0; i < 8; i++) pb(8'h00); close_frame("R4 buf0", 9);
      run_req(3'd3);
      chk(rx_id == 29'h123 && !rx_ext, "R5 standard id", {rx_ext, rx_id}, 29'h123);
      chk(rx_len == 4'd3, "R4 length", rx_len, 3);
      chk(rx_data == 64'h332211, "R4 data", rx_data, 64'h332211);

      // R4/R5 fast read buffer 1, extended id, length 12 clamped to 8
      clear_resp();
      w = pack_ext(29'h1ABCDEF5);
      resp[1] = w[31:24]; resp[2] = w[23:16]; resp[3] = w[15:8]; resp[4] = w[7:0];
      resp[5] = 8'h0C; ed = '0;
      for (int i = 0; i < 10; i++) resp[6 + i] = 8'hA0 + 8'(i);
      for (int i = 0; i < 8; i++) ed[8*i +: 8] = 8'hA0 + 8'(i);
      buf_sel = 2'd1;
      pb(8'h94); for (int i = 0; i < 13; i++) pb(8'h00); close_frame("R4 buf1 clamp", 14);
      run_req(3'd3);
      chk(rx_id == 29'h1ABCDEF5 && rx_ext, "R5 extended id", {rx_ext, rx_id}, {1'b1, 29'h1ABCDEF5});
      chk(rx_len == 4'd8, "R4 clamped length", rx_len, 8);
      chk(rx_data == ed, "R4 clamped data", rx_data, ed);

      // R6/R7 transmit, buffer select 3 acts as 2, extended id, priority 3
      clear_resp();
      buf_sel = 2'd3; tx_id = 29'h1ABCDEF5; tx_ext = 1'b1; tx_len = 4'd2;
      tx_data = 64'hC2C1; tx_prio = 2'd3;
      w = pack_ext(29'h1ABCDEF5);
      pb(8'h44); pb(w[31:24]); pb(w[23:16]); pb(w[15:8]); pb(w[7:0]);
      pb(8'h02); pb(8'hC1); pb(8'hC2); close_frame("R6 ext buf2", 8);
      pb(8'h02); pb(8'h50); pb(8'h0B); close_frame("R7 buf2 request", 3);
      run_req(3'd4);

      // R6/R7/R11 transmit buffer 0, standard id, length 10 clamped
      buf_sel = 2'd0; tx_id = 29'h5A5; tx_ext = 1'b0; tx_len = 4'd10;
      tx_data = 64'h8877665544332211; tx_prio = 2'd1;
      pb(8'h40); pb(8'(29'h5A5 >> 3)); pb(8'((29'h5A5 & 29'h7) << 5)); pb(8'h00); pb(8'h00);
      pb(8'h08); for (int i = 0; i < 8; i++) pb(tx_data[8*i +: 8]);
      close_frame("R11 std buf0 clamp", 14);
      pb(8'h02); pb(8'h30); pb(8'h09); close_frame("R7 buf0 request", 3);
      run_req(3'd4);

      // R6/R7 transmit buffer 1, zero length
      buf_sel = 2'd1; tx_id = 29'h001; tx_len = 4'd0; tx_prio = 2'd0;
      pb(8'h42); pb(8'h00); pb(8'h20); pb(8'h00); pb(8'h00); pb(8'h00);
      close_frame("R6 std buf1", 6);
      pb(8'h02); pb(8'h40); pb(8'h08); close_frame("R7 buf1 request", 3);
      run_req(3'd4);

      // R10 start while busy is ignored
      addr = 8'h11; wdata = 8'h5A;
      pb(8'h02); pb(8'h11); pb(8'h5A); close_frame("R2 during ignore", 3);
      f0 = frames;
      @(negedge clk); op = 3'd1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (4) @(negedge clk);
      op = 3'd0; start = 1'b1; @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
      repeat (60) @(negedge clk);
      chk(frames == f0 + 1 && !busy && spi_cs_n, "R10 start while busy ignored", 64'(frames - f0), 1);

      // R10 unknown op ignored
      f0 = frames;
      @(negedge clk); op = 3'd7; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (30) @(negedge clk);
      chk(frames == f0 && !busy && spi_cs_n && !done, "R10 bad op ignored", 64'(frames - f0), 0);

      chk(exp_n.size() == 0, "R10 all windows seen", 64'(exp_n.size()), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule